// File: doc/BRIEF.md
# Supply-Monitor Reset Pulse Generator

This block turns a digital "supply above threshold" flag and a one-cycle watchdog expiry pulse into the processor reset outputs. Reset is held for as long as the supply flag is low. Once the flag returns, reset is stretched for a fixed number of clock ticks before it is released. A watchdog expiry also opens a reset pulse of that same width. Any new trigger that arrives while a pulse is running starts the full width again. Two reset outputs are provided, one active-low and one active-high, and they are always complementary. A third output, `reset_active`, goes to the watchdog so that the watchdog can keep its timer clear while reset is asserted.

The pulse width is the parameter `RESET_TICKS`. At a clock of a few tens of MHz, a value in the millions gives a width in the hundreds of milliseconds. The block's own reset input asserts the reset outputs at once, without waiting for a clock edge, before any supply sample has been taken.

Top module: `supply_reset_gen`

## Requirements
- R1: While `supply_ok` is sampled 0 at a rising edge, the reset outputs are asserted after that edge (`rst_out`=1, `rst_out_n`=0).
- R2: After the last rising edge that samples a trigger, reset stays asserted through the next RESET_TICKS-1 trigger-free edges. It deasserts on the RESET_TICKS-th trigger-free edge. A trigger is `supply_ok`=0 or `wdog_expire`=1.
- R3: If `supply_ok` drops to 0 while a pulse is counting down, the count restarts, and the full RESET_TICKS width follows the recovery.
- R4: A `wdog_expire`=1 sampled with `supply_ok`=1 asserts reset after that edge, whether reset was released or already counting down, and opens a full-width pulse.
- R5: `rst_out` is the exact logical inverse of `rst_out_n` at all times.
- R6: Every reset pulse, whatever its cause, lasts at least RESET_TICKS clock cycles.
- R7: `reset_active` equals `rst_out` in every cycle.
- R8: Driving `rst_n` low asserts reset immediately and asynchronously. After `rst_n` is released, reset holds for RESET_TICKS edges even with `supply_ok`=1 throughout.
- R9: A `wdog_expire` pulse while `supply_ok`=0 adds no extra width: release still follows R2, counted from the last low-supply edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| supply_ok | input | 1 | 1 when the supply is above the reset threshold |
| wdog_expire | input | 1 | One-cycle watchdog timeout pulse |
| rst_out_n | output | 1 | Active-low processor reset |
| rst_out | output | 1 | Active-high processor reset |
| reset_active | output | 1 | Reset-asserted status returned to the watchdog |

## Verification
The hardest case to reach is a new trigger landing inside a pulse that is already partly counted down, and in particular on its final tick. A plain start/stop test never shows whether the countdown was restarted or only paused. The stimulus table therefore injects a supply dip two ticks into a pulse and a watchdog expiry two ticks into another. It then counts the exact number of asserted cycles until release. A watchdog pulse is also placed inside a low-supply window, to show that it does not lengthen the pulse after recovery.

// File: rtl/supply_reset_gen.sv
module supply_reset_gen #(
  parameter int unsigned RESET_TICKS = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic wdog_expire,
  output logic rst_out_n,
  output logic rst_out,
  output logic reset_active
);
  localparam int unsigned CW = $clog2(RESET_TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(RESET_TICKS);

  logic [CW-1:0] hold_cnt;
  logic          trigger;
  logic          held;

  assign trigger = !supply_ok || wdog_expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hold_cnt <= LOAD;
    else if (trigger)          hold_cnt <= LOAD;
    else if (hold_cnt != '0)   hold_cnt <= hold_cnt - 1'b1;
  end

  assign held         = (hold_cnt != '0);
  assign rst_out      = held;
  assign rst_out_n    = !held;
  assign reset_active = held;
endmodule

// File: rtl/supply_reset_gen_chk.sv
module supply_reset_gen_chk #(
  parameter int unsigned RESET_TICKS = 10_000_000
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic wdog_expire,
  input logic rst_out_n,
  input logic rst_out,
  input logic reset_active
);
  localparam int unsigned CW = $clog2(RESET_TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(RESET_TICKS);

  logic [CW-1:0] run_len;
  logic [CW-1:0] since_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len  <= '0;
      since_ev <= '0;
    end else begin
      if (!rst_out)            run_len <= '0;
      else if (run_len != LIM) run_len <= run_len + 1'b1;
      if (!supply_ok || wdog_expire) since_ev <= '0;
      else if (since_ev != LIM)      since_ev <= since_ev + 1'b1;
    end
  end

  a_r1_low_supply: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (rst_out && !rst_out_n));
  a_r2_release_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> $past(supply_ok));
  a_r3_restart_full: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> (since_ev >= LIM));
  a_r4_wdog_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && wdog_expire) |=> rst_out);
  a_r5_complement: assert property (@(posedge clk) disable iff (!rst_n)
    rst_out != rst_out_n);
  a_r6_min_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out) |-> (run_len >= LIM));
  a_r7_status_match: assert property (@(posedge clk) disable iff (!rst_n)
    reset_active == rst_out);
endmodule

bind supply_reset_gen supply_reset_gen_chk #(.RESET_TICKS(RESET_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wdog_expire(wdog_expire),
  .rst_out_n(rst_out_n), .rst_out(rst_out), .reset_active(reset_active)
);

// File: tb/supply_reset_gen_test.sv
module supply_reset_gen_test;
  localparam int unsigned T = 4;
  localparam int NV = 31;
  // {supply_ok, wdog_expire, expected rst_out, requirement number}
  localparam logic [6:0] VEC [NV] = '{
    {3'b101,4'd8}, {3'b101,4'd8}, {3'b101,4'd8}, {3'b100,4'd8}, {3'b100,4'd2},
    {3'b111,4'd4}, {3'b101,4'd6}, {3'b101,4'd6}, {3'b101,4'd6}, {3'b100,4'd2},
    {3'b001,4'd1}, {3'b001,4'd1}, {3'b101,4'd2}, {3'b101,4'd2}, {3'b001,4'd3},
    {3'b101,4'd3}, {3'b101,4'd3}, {3'b101,4'd3}, {3'b100,4'd3}, {3'b111,4'd4},
    {3'b101,4'd4}, {3'b111,4'd4}, {3'b101,4'd4}, {3'b101,4'd4}, {3'b101,4'd4},
    {3'b100,4'd6}, {3'b011,4'd9}, {3'b101,4'd9}, {3'b101,4'd9}, {3'b101,4'd9},
    {3'b100,4'd9}
  };

  logic clk = 0, rst_n = 1, supply_ok = 1, wdog_expire = 0;
  logic rst_out_n, rst_out, reset_active;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  supply_reset_gen #(.RESET_TICKS(T)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .wdog_expire(wdog_expire),
    .rst_out_n(rst_out_n), .rst_out(rst_out), .reset_active(reset_active)
  );

  function automatic string tag_of(int n);
    case (n)
      1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
      6: return "R6"; 8: return "R8"; 9: return "R9"; default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, logic exp);
    checks++;
    if (rst_out !== exp || rst_out_n !== !exp || reset_active !== exp) begin
      fails++;
      $display("FAIL %s: rst_out=%b rst_out_n=%b reset_active=%b expected %b/%b/%b (R5 R7 included)",
               tag, rst_out, rst_out_n, reset_active, exp, !exp, exp);
    end
  endtask

  task automatic step(logic s, logic w, string tag, logic exp);
    supply_ok = s; wdog_expire = w;
    @(posedge clk); #5;
    chk(tag, exp);
    @(negedge clk);
  endtask

  initial begin
    #3 rst_n = 0;
    #1 chk("R8 async assert at reset", 1'b1);
    repeat (3) @(negedge clk);
    chk("R8 held during reset", 1'b1);
    rst_n = 1;
    for (int i = 0; i < NV; i++)
      step(VEC[i][6], VEC[i][5], tag_of(int'(VEC[i][3:0])), VEC[i][4]);

    // R1: long low-supply window, then exact release count (R2)
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, "R1 long low supply", 1'b1);
    for (int i = 1; i < T; i++) step(1'b1, 1'b0, "R2 hold after recovery", 1'b1);
    step(1'b1, 1'b0, "R2 release on last tick", 1'b0);

    // R3: dip on the final tick of a running pulse
    step(1'b0, 1'b0, "R3 dip start", 1'b1);
    for (int i = 1; i < T; i++) step(1'b1, 1'b0, "R3 counting", 1'b1);
    step(1'b0, 1'b0, "R3 dip on final tick", 1'b1);
    for (int i = 1; i < T; i++) step(1'b1, 1'b0, "R3 full width again", 1'b1);
    step(1'b1, 1'b0, "R3 release", 1'b0);

    // R8: asynchronous block reset away from a clock edge while released
    #4 rst_n = 0;
    #1 chk("R8 immediate assert mid-cycle", 1'b1);
    @(negedge clk); rst_n = 1;
    for (int i = 1; i < T; i++) step(1'b1, 1'b0, "R8 post-reset hold", 1'b1);
    step(1'b1, 1'b0, "R8 post-reset release", 1'b0);
    step(1'b1, 1'b0, "R2 stays released", 1'b0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule